// File: doc/BRIEF.md
# Buffered Three-Mode PWM Timer

This block is one 16-bit PWM timer channel. It runs in one of three modes. Two modes are triangular, where the counter goes up to a period value and then back down to zero. The third is sawtooth, where the counter goes up to the period value and clears. The count clock comes from a prescaler, which passes one base-clock cycle out of 1, 2, 4, 8, 16 or 32.

The period register and five compare registers each have a write buffer and an active register. Software writes the buffer. When the timer is stopped, a write also goes straight into the active register. When the timer is running, a write waits for the transfer point of the current mode. This lets a new period and new duty values take effect together at a clean cycle boundary.

The block raises single-cycle pulses on the period event, on the zero turnaround and on each compare match. A downstream controller or waveform stage uses these pulses. Each of the two main event outputs has a mask that only gates its pulse.

Top module: `pwm3_timer`

## Requirements
- R1: While `en_i` is 0 (and after reset), the counter holds 0 with `dir_down_o`=0, and no event output pulses. After reset all buffers and active registers are 0.
- R2: The counter changes only on prescaler ticks. `psc_sel_i` value s in 0..5 gives one tick every 2^s base-clock cycles, and values 6 and 7 give one tick every 32 cycles.
- R3: In sawtooth mode (`mode_i`=2 or 3) the counter steps 0,1,…,P and returns to 0 on the tick after it equals the active period P. `prd_evt_o` pulses on the tick where the count equals P.
- R4: In the triangular modes (`mode_i`=0 symmetric, `mode_i`=1 asymmetric), on a tick while counting up with count ≥ P, the counter turns to counting down (`dir_down_o`=1) and `prd_evt_o` pulses. On a tick while counting down with count 0, it turns back up (`dir_down_o`=0) and `udf_evt_o` pulses.
- R5: A write while `en_i`=0 updates the active register in the next cycle. `wr_idx_i`=0 selects the period, and `wr_idx_i`=k (1..5) selects compare k.
- R6: In symmetric mode, buffered period and compare values become active only at the zero-turnaround event.
- R7: In asymmetric mode, the buffered period becomes active only at the zero turnaround. Buffered compare values become active at both the zero turnaround and the period event.
- R8: In sawtooth mode, all buffered values become active at the period match.
- R9: `prd_mask_i` and `udf_mask_i` suppress their pulses only. Counting, direction changes and transfers are unchanged.
- R10: `cmp_evt_o[k-1]` pulses on a tick where the count equals active compare k. Compare matches never alter counting. Active compare k appears on `cmp_act_o[16k-1:16(k-1)]`.
- R11: Every event output is high only on prescaler-tick cycles. With a divider above 1, each event pulse therefore lasts a single cycle.
- R12: Clearing `en_i` restarts the prescaler phase. After re-enabling, the first count step comes a full divider interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; 0 stops and clears the counter |
| mode_i | input | 2 | 0 symmetric triangular, 1 asymmetric triangular, 2/3 sawtooth |
| psc_sel_i | input | 3 | Prescaler select, divide by 2^min(sel,5) |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_idx_i | input | 3 | 0 period buffer, 1..5 compare buffer |
| wr_data_i | input | 16 | Buffer write data |
| prd_mask_i | input | 1 | Suppress `prd_evt_o` pulses |
| udf_mask_i | input | 1 | Suppress `udf_evt_o` pulses |
| cnt_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| prd_evt_o | output | 1 | Period event pulse |
| udf_evt_o | output | 1 | Zero-turnaround event pulse |
| cmp_evt_o | output | 5 | Compare match pulses |
| prd_act_o | output | 16 | Active period value |
| cmp_act_o | output | 80 | Active compare values, compare 1 in the low field |

## Verification
The assertions assume that `mode_i` and `psc_sel_i` change only while `en_i` is low. They assume the period stays at or above the count whenever a running triangular channel is checked at a turnaround. Each bench task therefore programs the mode, the prescaler and the starting buffers with the timer stopped, and only then raises the enable. The mid-run buffer writes land at counts where no transfer can coincide with them. This lets the expected model place each new value at one known event.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic [1:0] {
    PWM_SYM   = 2'd0,
    PWM_ASYM  = 2'd1,
    PWM_SAW   = 2'd2,
    PWM_SAW_X = 2'd3
  } pwm_mode_e;

  function automatic logic is_saw(input pwm_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/pwm3_prescaler.sv
module pwm3_prescaler #(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CW = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [CW-1:0]    div_q;
  logic [SEL_W-1:0] shift;
  logic [CW-1:0]    lim;

  always_comb begin
    shift = (sel_i > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel_i;
    lim   = {CW{1'b1}} >> (SEL_W'(CW) - shift);
  end

  assign tick_o = en_i & (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         saw_i,
  input  logic [W-1:0] prd_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         peak_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;
  logic         saw_hit, tri_peak, tri_zero, ovf;

  assign saw_hit  = saw_i & (cnt_q == prd_i);
  assign ovf      = saw_i & (cnt_q == {W{1'b1}});
  assign tri_peak = ~saw_i & ~dn_q & (cnt_q >= prd_i);
  assign tri_zero = ~saw_i & dn_q & (cnt_q == '0);

  assign peak_o = tick_i & (saw_hit | tri_peak);
  assign zero_o = tick_i & tri_zero;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    if (!en_i) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick_i) begin
      if (saw_i) begin
        dn_d  = 1'b0;
        cnt_d = (saw_hit || ovf) ? '0 : cnt_q + 1'b1;
      end else if (!dn_q) begin
        if (tri_peak) begin
          dn_d  = 1'b1;
          cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (tri_zero) begin
          dn_d  = 1'b0;
          cnt_d = (prd_i == '0) ? '0 : W'(1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = dn_q;
endmodule

// File: rtl/pwm3_bufbank.sv
module pwm3_bufbank #(
  parameter int W    = 16,
  parameter int NREG = 6,
  parameter int IW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            wr_en_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic            xfer_prd_i,
  input  logic            xfer_cmp_i,
  output logic [NREG*W-1:0] act_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [W-1:0] buf_q, act_q;
    logic         sel, xfer;

    assign sel  = wr_en_i & (wr_idx_i == IW'(k));
    // slot 0 holds the period; the rest are duty compares
    if (k == 0) begin : g_prd
      assign xfer = xfer_prd_i;
    end else begin : g_cmp
      assign xfer = xfer_cmp_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        if (sel) buf_q <= wr_data_i;
        if (!en_i) begin
          if (sel) act_q <= wr_data_i;
        end else if (xfer) begin
          act_q <= buf_q;
        end
      end
    end

    assign act_o[k*W +: W] = act_q;
  end
endmodule

// File: rtl/pwm3_cmp.sv
module pwm3_cmp #(
  parameter int W = 16,
  parameter int N = 5
) (
  input  logic           tick_i,
  input  logic [W-1:0]   cnt_i,
  input  logic [N*W-1:0] act_i,
  output logic [N-1:0]   evt_o
);
  for (genvar k = 0; k < N; k++) begin : g_m
    assign evt_o[k] = tick_i & (cnt_i == act_i[k*W +: W]);
  end
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int NUM_CMP       = 5,
  parameter int PSC_SEL_W     = 3,
  parameter int PSC_MAX_SHIFT = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [1:0]                    mode_i,
  input  logic [PSC_SEL_W-1:0]          psc_sel_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(NUM_CMP+1)-1:0]  wr_idx_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic                          prd_mask_i,
  input  logic                          udf_mask_i,
  output logic [CNT_W-1:0]              cnt_o,
  output logic                          dir_down_o,
  output logic                          prd_evt_o,
  output logic                          udf_evt_o,
  output logic [NUM_CMP-1:0]            cmp_evt_o,
  output logic [CNT_W-1:0]              prd_act_o,
  output logic [NUM_CMP*CNT_W-1:0]      cmp_act_o
);
  localparam int NREG = NUM_CMP + 1;
  localparam int IW   = $clog2(NREG);

  pwm_mode_e          mode;
  logic               saw, asym, tick, peak, zero;
  logic               xfer_prd, xfer_cmp;
  logic [NREG*CNT_W-1:0] act;

  assign mode = pwm_mode_e'(mode_i);
  assign saw  = is_saw(mode);
  assign asym = (mode == PWM_ASYM);

  pwm3_prescaler #(.SEL_W(PSC_SEL_W), .MAX_SHIFT(PSC_MAX_SHIFT)) u_psc (
    .clk_i, .rst_ni, .en_i, .sel_i(psc_sel_i), .tick_o(tick)
  );

  pwm3_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .saw_i(saw),
    .prd_i(act[0 +: CNT_W]), .cnt_o, .down_o(dir_down_o),
    .peak_o(peak), .zero_o(zero)
  );

  // transfer points per mode
  assign xfer_prd = saw ? peak : zero;
  assign xfer_cmp = saw ? peak : (zero | (asym & peak));

  pwm3_bufbank #(.W(CNT_W), .NREG(NREG), .IW(IW)) u_buf (
    .clk_i, .rst_ni, .en_i, .wr_en_i, .wr_idx_i, .wr_data_i,
    .xfer_prd_i(xfer_prd), .xfer_cmp_i(xfer_cmp), .act_o(act)
  );

  pwm3_cmp #(.W(CNT_W), .N(NUM_CMP)) u_cmp (
    .tick_i(tick), .cnt_i(cnt_o), .act_i(act[CNT_W +: NUM_CMP*CNT_W]),
    .evt_o(cmp_evt_o)
  );

  assign prd_evt_o = peak & ~prd_mask_i;
  assign udf_evt_o = zero & ~udf_mask_i;
  assign prd_act_o = act[0 +: CNT_W];
  assign cmp_act_o = act[CNT_W +: NUM_CMP*CNT_W];
endmodule

// File: rtl/pwm3_timer_chk.sv
module pwm3_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [1:0]         mode_i,
  input logic               tick_i,
  input logic [CNT_W-1:0]   cnt_o,
  input logic               dir_down_o,
  input logic               prd_evt_o,
  input logic               udf_evt_o,
  input logic [NUM_CMP-1:0] cmp_evt_o
);
  a_r1_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == '0 && !dir_down_o));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!prd_evt_o && !udf_evt_o && cmp_evt_o == '0));

  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_o));

  a_r3_saw_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i[1] && prd_evt_o) |=> cnt_o == '0);

  a_r4_peak_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mode_i[1] && prd_evt_o) |=> dir_down_o);

  a_r4_udf_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_evt_o |=> !dir_down_o);

  a_r11_prd_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_evt_o |-> tick_i);

  a_r11_udf_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_evt_o |-> tick_i);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_c
    a_r10_cmp_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_evt_o[k] |-> tick_i);
  end
endmodule

bind pwm3_timer pwm3_timer_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
  .tick_i(tick), .cnt_o(cnt_o), .dir_down_o(dir_down_o),
  .prd_evt_o(prd_evt_o), .udf_evt_o(udf_evt_o), .cmp_evt_o(cmp_evt_o)
);

// File: tb/pwm3_timer_bench.sv
module pwm3_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [2:0]  sel = 3'd0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic        pm = 1'b0, um = 1'b0;
  logic [15:0] cnt, prd_act;
  logic        dn, prd_evt, udf_evt;
  logic [4:0]  cmp_evt;
  logic [79:0] cmp_act;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm3_timer u_pwm3_timer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .psc_sel_i(sel),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .prd_mask_i(pm), .udf_mask_i(um), .cnt_o(cnt), .dir_down_o(dn),
    .prd_evt_o(prd_evt), .udf_evt_o(udf_evt), .cmp_evt_o(cmp_evt),
    .prd_act_o(prd_act), .cmp_act_o(cmp_act)
  );

  task automatic chk(input string tag, input int a, input int e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, a, e);
    end
  endtask

  // call at a negedge; returns at the next negedge
  task automatic wr_buf(input int idx, input int val);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 16'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 cnt", cnt, 0);
    chk("R1 dir", dn, 0);
    chk("R1 prd_act", prd_act, 0);
    chk("R1 events", {prd_evt, udf_evt, cmp_evt}, 0);
  endtask

  task automatic t_disabled_write;
    @(negedge clk);
    wr_buf(0, 7);
    #1 chk("R5 prd_act", prd_act, 7);
    @(negedge clk);
    wr_buf(3, 9);
    #1 chk("R5 cmp3_act", cmp_act[47:32], 9);
    wr_buf(3, 16'hFFFF);
  endtask

  task automatic run_mode(input int md, input int p0, input int c0, input int p1,
                          input int c1, input bit mp, input bit mu, input int cyc);
    int c = 0, d = 0, P = p0, C = c0, bp = p0, bc = c0;
    bit saw, peak, zero, xp, xc;
    string tc, tp, ta;
    saw = (md >= 2);
    tc = saw ? "R3" : "R4";
    ta = (md == 0) ? "R6" : (md == 1) ? "R7" : "R8";
    en = 1'b0; mode = 2'(md); sel = 3'd0; pm = mp; um = mu;
    @(negedge clk);
    wr_buf(0, p0);
    wr_buf(1, c0);
    en = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      #1;
      peak = saw ? (c == P) : (d == 0 && c >= P);
      zero = !saw && d == 1 && c == 0;
      tp = mp ? "R9" : tc;
      chk({tc, " cnt"}, cnt, c);
      chk({tc, " dir"}, dn, d);
      chk({tp, " prd_evt"}, prd_evt, peak && !mp);
      chk({mu ? "R9" : "R4", " udf_evt"}, udf_evt, zero && !mu);
      chk("R10 cmp_evt", cmp_evt[0], c == C);
      chk({ta, " prd_act"}, prd_act, P);
      chk({ta, " cmp_act"}, cmp_act[15:0], C);
      xp = saw ? peak : zero;
      xc = saw ? peak : (zero || (md == 1 && peak));
      if (saw) c = peak ? 0 : c + 1;
      else if (d == 0) begin
        if (peak) begin d = 1; c = (c == 0) ? 0 : c - 1; end else c = c + 1;
      end else begin
        if (zero) begin d = 0; c = (P == 0) ? 0 : 1; end else c = c - 1;
      end
      if (xp) P = bp;
      if (xc) C = bc;
      if (i == 1) bp = p1;
      if (i == 2) bc = c1;
      wr_en = (i == 1 || i == 2);
      wr_idx = (i == 1) ? 3'd0 : 3'd1;
      wr_data = 16'((i == 1) ? p1 : c1);
      @(negedge clk);
    end
    wr_en = 1'b0; en = 1'b0; pm = 1'b0; um = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_prescaler;
    int sels[5] = '{0, 1, 3, 5, 7};
    mode = 2'd2;
    @(negedge clk);
    wr_buf(0, 1000);
    foreach (sels[j]) begin
      int dv;
      dv = 1 << ((sels[j] > 5) ? 5 : sels[j]);
      sel = 3'(sels[j]);
      en = 1'b1;
      repeat (4 * dv) @(posedge clk);
      @(negedge clk);
      #1 chk($sformatf("R2 cnt sel%0d", sels[j]), cnt, 4);
      en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_phase_restart;
    mode = 2'd2; sel = 3'd3;
    @(negedge clk);
    en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk);
    #1 chk("R12 cnt before step", cnt, 0);
    @(negedge clk);
    #1 chk("R12 cnt after step", cnt, 1);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_tick_pulse;
    int hi = 0, back = 0;
    bit prev = 1'b0;
    mode = 2'd2; sel = 3'd2;
    @(negedge clk);
    wr_buf(0, 1);
    en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      #1;
      if (prd_evt) hi++;
      if (prd_evt && prev) back++;
      prev = prd_evt;
      @(negedge clk);
    end
    chk("R11 pulse count", hi, 2);
    chk("R11 back-to-back", back, 0);
    en = 1'b0; sel = 3'd0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled_write();
    run_mode(0, 3, 2, 5, 1, 1'b0, 1'b0, 20);
    run_mode(1, 3, 2, 5, 1, 1'b0, 1'b0, 20);
    run_mode(2, 4, 2, 6, 3, 1'b0, 1'b0, 18);
    run_mode(0, 2, 1, 2, 1, 1'b1, 1'b1, 12);
    t_prescaler();
    t_phase_restart();
    t_tick_pulse();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule